// File: doc/BRIEF.md
# Flash Write-Cycle Command Sequencer

This block interprets the bus writes sent to a parallel NOR flash that uses the classic two-step command protocol. A write's low byte opens a command in its first cycle. Later writes then carry data, a word count or a confirm byte, depending on which command is open. The block holds a small byte-addressable array that is split into equal sectors. Every program and erase finishes within the clock cycle of the write, so no device timing is modelled.

Reads are served according to the current mode. In array mode a read returns little-endian array data. While a program, erase, lock, status or buffered-write command is active, a read returns the status byte copied into every device-width slice of the access. In identifier and query modes the block returns zero and signals the mode on `rmode`, so that a separate formatter can supply the tables. A read-only input blocks every change to the array and sets the matching error bit in the status register.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset the read mode is array (`rmode`=0), every array byte reads 0xFF, the cycle counter is 0 and the status register is 0x80.
- R2: In cycle 0, a command byte of 0x10 or 0x40 opens a program. The next write stores its data little-endian at its own address for its size (`wsize` 0=1 byte, 1=2 bytes, 2=4 bytes), sets status bit 7 and returns to cycle 0.
- R3: In cycle 0, the byte 0x20 fills the sector that holds the address with 0xFF. The next write of 0xD0 completes it and leaves status mode. 0xFF, or any other byte, returns to array mode.
- R4: When `read_only` is high the array does not change. An erase sets status bit 5 and a program sets status bit 4, and bit 7 is set in both cases.
- R5: The byte 0x50 in cycle 0 clears the whole status register and selects array mode.
- R6: The bytes 0x70 (status) and 0x90 (identifier) change the read mode but keep the cycle counter at 0, so the next write is decoded as a new command.
- R7: The byte 0xE8 opens a buffered write. The next write supplies a count, taken from its low DEV_BYTES*8 bits. Count+1 data writes follow, and then 0xD0 completes the command in status mode. Any other final byte returns to array mode.
- R8: In cycle 0, the bytes 0xFF, 0xF0, 0x00 and any unassigned byte select array mode.
- R9: After 0x60, a next write of 0xD0 or 0x01 completes the command in status mode. Any other byte returns to array mode.
- R10: The byte 0x98 selects query mode. Later writes keep query mode unless the byte is 0xFF, which selects array mode.
- R11: A status-mode read places the status byte in the low byte of each DEV_BYTES-wide slice within the access width and zeros in every other byte.
- R12: `rmode` encodes 0 for array, 1 for status, 2 for identifier and 3 for query. `rdata` is zero for reads in identifier or query mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe; `rdata` is valid one cycle later |
| addr | input | ADDR_W | Byte address of the access |
| wsize | input | 2 | Access size: 0=1 byte, 1=2 bytes, 2=4 bytes |
| wdata | input | 32 | Write data; the command byte is bits 7:0 |
| read_only | input | 1 | Blocks every change to the array |
| rdata | output | 32 | Registered read data |
| rmode | output | 2 | Current read mode |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle and that `wsize` never takes the value 3. They also assume that `read_only` changes only between accesses, and never in the same cycle as a write strobe. The bench drives one access per strobe from its tasks, releases the strobe on the next falling edge, and changes `read_only` only while both strobes are low. Every multi-byte access it issues is naturally aligned inside the array, so no access wraps past the top address.

// File: rtl/nce_pkg.sv
package nce_pkg;

  typedef enum logic [2:0] {
    M_ARRAY, M_PROG, M_ERASE, M_LOCK, M_STATUS, M_IDENT, M_QUERY, M_BUFW
  } cmd_e;

  localparam logic [1:0] RM_ARRAY  = 2'd0;
  localparam logic [1:0] RM_STATUS = 2'd1;
  localparam logic [1:0] RM_IDENT  = 2'd2;
  localparam logic [1:0] RM_QUERY  = 2'd3;

  localparam logic [7:0] CB_PROG_A = 8'h10;
  localparam logic [7:0] CB_PROG_B = 8'h40;
  localparam logic [7:0] CB_ERASE  = 8'h20;
  localparam logic [7:0] CB_CLEAR  = 8'h50;
  localparam logic [7:0] CB_LOCK   = 8'h60;
  localparam logic [7:0] CB_STAT   = 8'h70;
  localparam logic [7:0] CB_IDENT  = 8'h90;
  localparam logic [7:0] CB_QUERY  = 8'h98;
  localparam logic [7:0] CB_BUFW   = 8'hE8;
  localparam logic [7:0] CB_OK     = 8'hD0;
  localparam logic [7:0] CB_ALT_OK = 8'h01;
  localparam logic [7:0] CB_ARRAY  = 8'hFF;

  function automatic logic [2:0] acc_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    acc_bytes = 3'd1;
      2'd1:    acc_bytes = 3'd2;
      default: acc_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/nce_seq.sv
module nce_seq
  import nce_pkg::*;
#(
  parameter int DEV_BYTES = 2,
  localparam int CNT_W = DEV_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] cmd_data,
  input  logic             read_only,
  output cmd_e             cmd_o,
  output logic [7:0]       status_o,
  output logic             prog_we,
  output logic             erase_we
);

  cmd_e             cmd_q;
  logic [1:0]       cyc_q;
  logic [7:0]       status_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       cb;
  logic [7:0]       ro_prog_err;
  logic [7:0]       ro_erase_err;

  assign cb           = cmd_data[7:0];
  assign ro_prog_err  = read_only ? 8'h10 : 8'h00;
  assign ro_erase_err = read_only ? 8'h20 : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= M_ARRAY;
      cyc_q    <= 2'd0;
      status_q <= 8'h80;
      cnt_q    <= '0;
    end else if (wr_en) begin
      case (cyc_q)
        2'd0: begin
          case (cb)
            CB_PROG_A, CB_PROG_B: begin
              cmd_q <= M_PROG;
              cyc_q <= 2'd1;
            end
            CB_ERASE: begin
              cmd_q    <= M_ERASE;
              cyc_q    <= 2'd1;
              status_q <= status_q | 8'h80 | ro_erase_err;
            end
            CB_CLEAR: begin
              cmd_q    <= M_ARRAY;
              status_q <= 8'h00;
            end
            CB_LOCK: begin
              cmd_q <= M_LOCK;
              cyc_q <= 2'd1;
            end
            CB_STAT:  cmd_q <= M_STATUS;
            CB_IDENT: cmd_q <= M_IDENT;
            CB_QUERY: begin
              cmd_q <= M_QUERY;
              cyc_q <= 2'd1;
            end
            CB_BUFW: begin
              cmd_q    <= M_BUFW;
              cyc_q    <= 2'd1;
              status_q <= status_q | 8'h80;
            end
            default: cmd_q <= M_ARRAY;
          endcase
        end
        2'd1: begin
          case (cmd_q)
            M_PROG: begin
              status_q <= status_q | 8'h80 | ro_prog_err;
              cyc_q    <= 2'd0;
            end
            M_ERASE: begin
              cyc_q <= 2'd0;
              if (cb == CB_OK) status_q <= status_q | 8'h80;
              else             cmd_q    <= M_ARRAY;
            end
            M_BUFW: begin
              cnt_q <= cmd_data;
              cyc_q <= 2'd2;
            end
            M_LOCK: begin
              cyc_q <= 2'd0;
              if (cb == CB_OK || cb == CB_ALT_OK) status_q <= status_q | 8'h80;
              else                                 cmd_q    <= M_ARRAY;
            end
            M_QUERY: begin
              if (cb == CB_ARRAY) begin
                cmd_q <= M_ARRAY;
                cyc_q <= 2'd0;
              end
            end
            default: begin
              cmd_q <= M_ARRAY;
              cyc_q <= 2'd0;
            end
          endcase
        end
        2'd2: begin
          if (cmd_q == M_BUFW) begin
            status_q <= status_q | 8'h80 | ro_prog_err;
            cnt_q    <= cnt_q - 1'b1;
            if (cnt_q == '0) cyc_q <= 2'd3;
          end else begin
            cmd_q <= M_ARRAY;
            cyc_q <= 2'd0;
          end
        end
        default: begin
          cyc_q <= 2'd0;
          if (cmd_q == M_BUFW && cb == CB_OK) status_q <= status_q | 8'h80;
          else                                cmd_q    <= M_ARRAY;
        end
      endcase
    end
  end

  assign prog_we  = wr_en && !read_only &&
                    ((cyc_q == 2'd1 && cmd_q == M_PROG) ||
                     (cyc_q == 2'd2 && cmd_q == M_BUFW));
  assign erase_we = wr_en && !read_only && cyc_q == 2'd0 && cb == CB_ERASE;

  assign cmd_o    = cmd_q;
  assign status_o = status_q;

  // R7
  bufw_last_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cyc_q == 2'd2 && cmd_q == M_BUFW && cnt_q == '0) |=> (cyc_q == 2'd3));

  // R7
  bufw_stage_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_q[1]) |-> (cmd_q == M_BUFW));

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cyc_q == 2'd0 && cb == CB_CLEAR) |=> (status_q == 8'h00 && cmd_q == M_ARRAY));

  // R4
  ro_prog_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && read_only && cyc_q == 2'd1 && cmd_q == M_PROG) |=> (status_q[4] && status_q[7]));

  // R6
  mode_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cyc_q == 2'd0 && (cb == CB_STAT || cb == CB_IDENT)) |=> (cyc_q == 2'd0));

endmodule

// File: rtl/nce_array.sv
module nce_array
  import nce_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int SECT_BYTES = 16,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int SECT_LG = $clog2(SECT_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_we,
  input  logic              erase_we,
  input  logic              read_only,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wsize,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_word
);

  logic [7:0]        mem_q [DEPTH];
  logic [ADDR_W-1:0] rel   [DEPTH];
  logic              in_sect [DEPTH];
  logic [2:0]        nbytes;

  assign nbytes = acc_bytes(wsize);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rel[i]     = ADDR_W'(i) - addr;
      in_sect[i] = (ADDR_W'(i) >> SECT_LG) == (addr >> SECT_LG);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst)
        mem_q[i] <= 8'hFF;
      else if (erase_we && in_sect[i])
        mem_q[i] <= 8'hFF;
      else if (prog_we && rel[i] < ADDR_W'(nbytes))
        mem_q[i] <= wdata[8*rel[i][1:0] +: 8];
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      rd_word[8*k +: 8] = (k < int'(nbytes)) ? mem_q[addr + ADDR_W'(k)] : 8'h00;
    end
  end

  // R4
  ro_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_we || erase_we) |-> !read_only);

endmodule

// File: rtl/nce_rdfmt.sv
module nce_rdfmt
  import nce_pkg::*;
#(
  parameter int DEV_BYTES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_en,
  input  cmd_e        cmd,
  input  logic [7:0]  status,
  input  logic [1:0]  wsize,
  input  logic [31:0] arr_word,
  output logic [31:0] rdata,
  output logic [1:0]  rmode
);

  logic [31:0] stat_word;
  logic [2:0]  nbytes;

  assign nbytes = acc_bytes(wsize);

  always_comb begin
    case (cmd)
      M_ARRAY: rmode = RM_ARRAY;
      M_IDENT: rmode = RM_IDENT;
      M_QUERY: rmode = RM_QUERY;
      default: rmode = RM_STATUS;
    endcase
  end

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      stat_word[8*k +: 8] = ((k % DEV_BYTES) == 0 && k < int'(nbytes)) ? status : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (rmode)
        RM_ARRAY:  rdata <= arr_word;
        RM_STATUS: rdata <= stat_word;
        default:   rdata <= '0;
      endcase
    end
  end

  // R12
  side_table_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rmode[1]) |=> (rdata == 32'h0));

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import nce_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int SECT_BYTES = 16,
  parameter int DEV_BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wsize,
  input  logic [31:0]       wdata,
  input  logic              read_only,
  output logic [31:0]       rdata,
  output logic [1:0]        rmode
);

  localparam int CNT_W = DEV_BYTES * 8;

  cmd_e        cmd;
  logic [7:0]  status;
  logic        prog_we;
  logic        erase_we;
  logic [31:0] arr_word;

  nce_seq #(.DEV_BYTES(DEV_BYTES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .cmd_data (wdata[CNT_W-1:0]),
    .read_only(read_only),
    .cmd_o    (cmd),
    .status_o (status),
    .prog_we  (prog_we),
    .erase_we (erase_we)
  );

  nce_array #(.ADDR_W(ADDR_W), .SECT_BYTES(SECT_BYTES)) u_array (
    .clk      (clk),
    .rst      (rst),
    .prog_we  (prog_we),
    .erase_we (erase_we),
    .read_only(read_only),
    .addr     (addr),
    .wsize    (wsize),
    .wdata    (wdata),
    .rd_word  (arr_word)
  );

  nce_rdfmt #(.DEV_BYTES(DEV_BYTES)) u_rdfmt (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .cmd     (cmd),
    .status  (status),
    .wsize   (wsize),
    .arr_word(arr_word),
    .rdata   (rdata),
    .rmode   (rmode)
  );

endmodule

// File: tb/nor_cmd_engine_tb.sv
module nor_cmd_engine_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [1:0]  wsize = '0;
  logic [31:0] wdata = '0;
  logic        read_only = 1'b0;
  logic [31:0] rdata;
  logic [1:0]  rmode;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nor_cmd_engine u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wsize(wsize), .wdata(wdata), .read_only(read_only),
    .rdata(rdata), .rmode(rmode)
  );

  typedef struct packed {
    logic        rd;
    logic [1:0]  sz;
    logic [5:0]  ad;
    logic [31:0] dt;
    logic [31:0] ex;
    logic [1:0]  md;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VT [NV] = '{
    '{1'b0, 2'd0, 6'd0,  32'h40,       32'h0,        2'd1, 4'd2 },  // R2 open program
    '{1'b0, 2'd2, 6'd4,  32'h44332211, 32'h0,        2'd1, 4'd2 },  // R2 word data
    '{1'b1, 2'd2, 6'd0,  32'h0,        32'h00800080, 2'd1, 4'd11},  // R11 4-byte status
    '{1'b0, 2'd0, 6'd0,  32'hFF,       32'h0,        2'd0, 4'd8 },  // R8 back to array
    '{1'b1, 2'd2, 6'd4,  32'h0,        32'h44332211, 2'd0, 4'd2 },  // R2 readback
    '{1'b1, 2'd1, 6'd6,  32'h0,        32'h00004433, 2'd0, 4'd2 },  // R2 half readback
    '{1'b0, 2'd0, 6'd0,  32'h10,       32'h0,        2'd1, 4'd2 },  // R2 alt program
    '{1'b0, 2'd1, 6'd8,  32'hBEEF,     32'h0,        2'd1, 4'd2 },  // R2 half data
    '{1'b0, 2'd0, 6'd0,  32'hF0,       32'h0,        2'd0, 4'd8 },  // R8 0xF0
    '{1'b1, 2'd0, 6'd9,  32'h0,        32'h000000BE, 2'd0, 4'd2 },  // R2 byte lane
    '{1'b0, 2'd0, 6'd5,  32'h20,       32'h0,        2'd1, 4'd3 },  // R3 erase sector 0
    '{1'b0, 2'd0, 6'd5,  32'hD0,       32'h0,        2'd1, 4'd3 },  // R3 confirm
    '{1'b1, 2'd1, 6'd0,  32'h0,        32'h00000080, 2'd1, 4'd11},  // R11 2-byte status
    '{1'b0, 2'd0, 6'd0,  32'hFF,       32'h0,        2'd0, 4'd8 },  // R8
    '{1'b1, 2'd2, 6'd4,  32'h0,        32'hFFFFFFFF, 2'd0, 4'd3 },  // R3 erased word
    '{1'b1, 2'd1, 6'd8,  32'h0,        32'h0000FFFF, 2'd0, 4'd3 },  // R3 erased half
    '{1'b0, 2'd0, 6'd0,  32'h90,       32'h0,        2'd2, 4'd6 },  // R6 identifier
    '{1'b1, 2'd2, 6'd0,  32'h0,        32'h0,        2'd2, 4'd12},  // R12 ident zero
    '{1'b0, 2'd0, 6'd0,  32'h98,       32'h0,        2'd3, 4'd10},  // R10 query
    '{1'b0, 2'd0, 6'd0,  32'h12,       32'h0,        2'd3, 4'd10},  // R10 stays
    '{1'b1, 2'd2, 6'd0,  32'h0,        32'h0,        2'd3, 4'd12},  // R12 query zero
    '{1'b0, 2'd0, 6'd0,  32'hFF,       32'h0,        2'd0, 4'd10},  // R10 leave
    '{1'b0, 2'd0, 6'd0,  32'h77,       32'h0,        2'd0, 4'd8 }   // R8 unknown byte
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [5:0] ad, input logic [31:0] dt);
    @(negedge clk);
    wr_en = 1'b1; wsize = sz; addr = ad; wdata = dt;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [5:0] ad, output logic [31:0] val);
    @(negedge clk);
    rd_en = 1'b1; wsize = sz; addr = ad;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    val = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 mode", {30'd0, rmode}, 32'd0);
    rd(2'd2, 6'd0, v);  chk("R1 array", v, 32'hFFFFFFFF);
    wr(2'd0, 6'd0, 32'h70);
    chk("R1 status mode", {30'd0, rmode}, 32'd1);
    rd(2'd0, 6'd0, v);  chk("R1 status", v, 32'h80);
    wr(2'd0, 6'd0, 32'hFF);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VT[i].rq, i);
      if (VT[i].rd) begin
        rd(VT[i].sz, VT[i].ad, v);
        chk({tag, " data"}, v, VT[i].ex);
      end else begin
        wr(VT[i].sz, VT[i].ad, VT[i].dt);
      end
      chk({tag, " mode"}, {30'd0, rmode}, {30'd0, VT[i].md});
    end

    // R4 read-only program and erase
    wr(2'd0, 6'd0, 32'h40); wr(2'd0, 6'd17, 32'h3C);
    wr(2'd0, 6'd0, 32'hFF);
    read_only = 1'b1;
    wr(2'd0, 6'd0, 32'h40); wr(2'd0, 6'd16, 32'h55);
    rd(2'd0, 6'd0, v);  chk("R4 program flag", v, 32'h90);
    wr(2'd0, 6'd16, 32'h20); wr(2'd0, 6'd16, 32'hD0);
    rd(2'd0, 6'd0, v);  chk("R4 erase flag", v, 32'hB0);
    wr(2'd0, 6'd0, 32'hFF);
    read_only = 1'b0;
    rd(2'd0, 6'd16, v); chk("R4 no program", v, 32'hFF);
    rd(2'd0, 6'd17, v); chk("R4 no erase", v, 32'h3C);

    // R5 clear status
    wr(2'd0, 6'd0, 32'h50);
    chk("R5 mode", {30'd0, rmode}, 32'd0);
    wr(2'd0, 6'd0, 32'h70);
    rd(2'd0, 6'd0, v);  chk("R5 cleared", v, 32'h00);

    // R6 status mode keeps cycle 0: next byte is a command
    wr(2'd0, 6'd0, 32'h40);
    chk("R6 new command", {30'd0, rmode}, 32'd1);
    wr(2'd0, 6'd20, 32'h5A); wr(2'd0, 6'd0, 32'hFF);
    rd(2'd0, 6'd20, v); chk("R6 program after status", v, 32'h5A);
    wr(2'd0, 6'd0, 32'h90); wr(2'd0, 6'd0, 32'h98);
    chk("R6 ident then query", {30'd0, rmode}, 32'd3);
    wr(2'd0, 6'd0, 32'hFF);

    // R3 abort with other byte
    wr(2'd0, 6'd32, 32'h20); wr(2'd0, 6'd32, 32'h33);
    chk("R3 bad confirm", {30'd0, rmode}, 32'd0);
    wr(2'd0, 6'd32, 32'h20); wr(2'd0, 6'd32, 32'hFF);
    chk("R3 abort FF", {30'd0, rmode}, 32'd0);

    // R7 buffered write, count 0x10002 masked to 2
    wr(2'd0, 6'd32, 32'hE8); wr(2'd2, 6'd32, 32'h00010002);
    wr(2'd0, 6'd32, 32'h01); wr(2'd0, 6'd33, 32'h02); wr(2'd0, 6'd34, 32'h03);
    wr(2'd0, 6'd32, 32'hD0);
    chk("R7 confirm mode", {30'd0, rmode}, 32'd1);
    wr(2'd0, 6'd0, 32'hFF);
    rd(2'd2, 6'd32, v); chk("R7 data", v, 32'hFF030201);
    wr(2'd0, 6'd40, 32'hE8); wr(2'd0, 6'd40, 32'h00);
    wr(2'd0, 6'd40, 32'h11); wr(2'd0, 6'd40, 32'h99);
    chk("R7 abort", {30'd0, rmode}, 32'd0);
    rd(2'd0, 6'd40, v); chk("R7 abort data", v, 32'h11);

    // R9 lock
    wr(2'd0, 6'd0, 32'h60); wr(2'd0, 6'd0, 32'h01);
    chk("R9 0x01", {30'd0, rmode}, 32'd1);
    wr(2'd0, 6'd0, 32'h60); wr(2'd0, 6'd0, 32'hD0);
    chk("R9 0xD0", {30'd0, rmode}, 32'd1);
    wr(2'd0, 6'd0, 32'h60); wr(2'd0, 6'd0, 32'h42);
    chk("R9 other", {30'd0, rmode}, 32'd0);

    // R11 one-byte status read
    wr(2'd0, 6'd0, 32'h70);
    rd(2'd0, 6'd0, v);  chk("R11 byte status", v, 32'h80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule